// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the address of an instruction fetch into a physical address, or into a fault code. Each cycle it takes one request: the fetch address, a flag that marks the address as already physical, the current privilege mode and the current address-space number. The page-table lookup itself is done outside the block. The block drives the virtual page number and the address-space number to an external translation buffer and reads back, in the same cycle, a hit flag, a physical page number and a per-mode execute-permission mask.

The block decides between five paths, in a fixed priority order:

1. A privileged-code bypass, chosen by address bit 0.
2. A physical passthrough.
3. Rejection of non-canonical addresses.
4. A kernel-only direct-mapped superpage window.
5. A normal page translation.

After that it checks the physical address against the implemented width and handles the uncacheable region. Results are registered and appear one clock after the request. Three event counters, for hits, misses and access violations, advance at the same time.

Top module: `ifx_xlate`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid` is 0 and all three counters read 0.
- R2: If fetch address bit 0 is 1, the result is the address with bits 1:0 cleared and every bit from 44 upward cleared. The fault is none and the uncacheable flag is 0. The TLB response and the physical flag are ignored, and the hit counter advances by one.
- R3: If bit 0 is 0 and `req_phys` is 1, the fetch address is taken unchanged as the physical address. It is still subject to R10 and R11, and no counter moves.
- R4: A translated address (bit 0 = 0, `req_phys` = 0) whose bits 63:48 are not all equal to bit 47 gives fault code 1 (access violation) and advances the violation counter.
- R5: If a canonical translated address has VA[47:41] = 7'h7E, it is a superpage. A superpage is allowed only in mode 0 (kernel). In modes 1 to 3 it gives fault code 1 and advances the violation counter.
- R6: A kernel superpage maps to VA with bits 63:44 cleared. If the resulting bit 40 is 1, bits 43:40 are then set to 1. Otherwise bits 43:40 are cleared.
- R7: Any other translated address is looked up. `tlb_vpn` equals VA[47:13] and `tlb_asn` equals `req_asn`. If `tlb_hit` is 0, the result is fault code 2 (page miss) and the miss counter advances.
- R8: On a TLB hit, the physical address is `tlb_ppn` shifted left by 13, plus VA[12:0] with bits 1:0 cleared.
- R9: On a TLB hit, execution is allowed only if `tlb_xperm[req_mode]` is 1. If it is, the hit counter advances. If it is not, the result is fault code 1 and the violation counter advances.
- R10: If the address from R3, R6 or R8 has any bit from 44 upward set, the result is fault code 3 (machine check).
- R11: If that address has bit 43 set and bits 42:32 all set, the result is fault code 4 (unimplemented). If bit 43 is set and bits 42:32 are not all set, the result has `rsp_uncached` = 1 and bits 42:35 cleared. Whenever the fault is non-zero, `rsp_paddr` and `rsp_uncached` are both 0.
- R12: Every result, and every counter change, appears exactly one clock edge after its request. `rsp_valid` repeats `req_valid` with that one-cycle delay, and a cycle without a request leaves the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Fetch address |
| req_phys | input | 1 | Address is already physical |
| req_mode | input | 2 | Current privilege mode, 0 = kernel |
| req_asn | input | 8 | Current address-space number |
| tlb_vpn | output | 35 | Page number presented to the TLB |
| tlb_asn | output | 8 | Address-space number presented to the TLB |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_xperm | input | 4 | Execute permission, one bit per mode |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 64 | Physical address, 0 on fault |
| rsp_uncached | output | 1 | Access goes to uncacheable space |
| rsp_fault | output | 3 | 0 none, 1 access violation, 2 page miss, 3 machine check, 4 unimplemented |
| cnt_hit | output | 16 | Hit events |
| cnt_miss | output | 16 | Page-miss events |
| cnt_acv | output | 16 | Access-violation events |

## Verification
The TLB lookup outputs depend only on the current inputs, so the bench samples them in the same low clock phase in which it drives the request. The address, flag, fault and all three counters come from one register stage. The bench therefore drives a request at the falling edge, lets one rising edge pass, and compares one time unit later. Its behavioural model advances its counters at that same point. Idle cycles are put between requests to show that `rsp_valid` drops and the counters hold.

// File: rtl/ifx_pkg.sv
`timescale 1ns/1ps
package ifx_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_MCHK  = 3'd3,
    FLT_UNIMP = 3'd4
  } ifx_fault_e;

  localparam int EV_HIT  = 0;
  localparam int EV_MISS = 1;
  localparam int EV_ACV  = 2;
  localparam int EV_N    = 3;
endpackage

// File: rtl/ifx_path.sv
`timescale 1ns/1ps
module ifx_path import ifx_pkg::*; #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 44,
  parameter int PG_SH   = 13,
  parameter int SP_LO   = 41,
  parameter logic [6:0] SP_TAG = 7'h7E,
  parameter int SX_BIT  = 40,
  parameter int UC_LO   = 35,
  parameter int IPR_LO  = 32
) (
  input  logic [63:0]           vaddr,
  input  logic                  phys,
  input  logic [1:0]            mode,
  input  logic                  tlb_hit,
  input  logic [PA_W-PG_SH-1:0] tlb_ppn,
  input  logic [3:0]            tlb_xperm,
  output logic [63:0]           paddr,
  output logic                  uncached,
  output ifx_fault_e            fault,
  output logic [EV_N-1:0]       ev
);
  localparam logic [63:0] IMPL_M = (64'd1 << PA_W) - 64'd1;
  localparam logic [63:0] LOW_M  = (64'd1 << SX_BIT) - 64'd1;
  localparam logic [63:0] SX_OR  = IMPL_M & ~LOW_M;

  logic [63:0] pa;
  logic        canon, post;
  ifx_fault_e  f;

  assign canon = (&vaddr[63:VA_W-1]) | ~(|vaddr[63:VA_W-1]);

  always_comb begin
    pa       = '0;
    f        = FLT_NONE;
    ev       = '0;
    uncached = 1'b0;
    post     = 1'b1;
    if (vaddr[0]) begin
      pa = {vaddr[63:2], 2'b00} & IMPL_M;
      ev[EV_HIT] = 1'b1;
      post = 1'b0;
    end else if (phys) begin
      pa = vaddr;
    end else if (!canon) begin
      f = FLT_ACV;
      ev[EV_ACV] = 1'b1;
      post = 1'b0;
    end else if (vaddr[VA_W-1:SP_LO] == SP_TAG) begin
      if (mode != 2'd0) begin
        f = FLT_ACV;
        ev[EV_ACV] = 1'b1;
        post = 1'b0;
      end else begin
        pa = vaddr & IMPL_M;
        if (pa[SX_BIT]) pa = pa | SX_OR;
        else            pa = pa & LOW_M;
      end
    end else if (!tlb_hit) begin
      f = FLT_MISS;
      ev[EV_MISS] = 1'b1;
      post = 1'b0;
    end else begin
      pa = (64'(tlb_ppn) << PG_SH) + (64'(vaddr[PG_SH-1:0]) & ~64'd3);
      if (!tlb_xperm[mode]) begin
        f = FLT_ACV;
        ev[EV_ACV] = 1'b1;
        post = 1'b0;
      end else begin
        ev[EV_HIT] = 1'b1;
      end
    end
    if (post) begin
      if (|(pa & ~IMPL_M)) begin
        f = FLT_MCHK;
      end else if (pa[PA_W-1]) begin
        if (&pa[PA_W-2:IPR_LO]) begin
          f = FLT_UNIMP;
        end else begin
          uncached = 1'b1;
          pa[PA_W-2:UC_LO] = '0;
        end
      end
    end
    fault = f;
    paddr = (f == FLT_NONE) ? pa : 64'd0;
    if (f != FLT_NONE) uncached = 1'b0;
  end
endmodule

// File: rtl/ifx_counters.sv
`timescale 1ns/1ps
module ifx_counters #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       inc,
  output logic [N*CNT_W-1:0] cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst)         c <= '0;
      else if (inc[i]) c <= c + 1'b1;
    end
    assign cnt[i*CNT_W +: CNT_W] = c;
  end
endmodule

// File: rtl/ifx_xlate.sv
`timescale 1ns/1ps
module ifx_xlate import ifx_pkg::*; #(
  parameter int VA_W  = 48,
  parameter int PA_W  = 44,
  parameter int PG_SH = 13,
  parameter int ASN_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [63:0]           req_vaddr,
  input  logic                  req_phys,
  input  logic [1:0]            req_mode,
  input  logic [ASN_W-1:0]      req_asn,
  output logic [VA_W-PG_SH-1:0] tlb_vpn,
  output logic [ASN_W-1:0]      tlb_asn,
  input  logic                  tlb_hit,
  input  logic [PA_W-PG_SH-1:0] tlb_ppn,
  input  logic [3:0]            tlb_xperm,
  output logic                  rsp_valid,
  output logic [63:0]           rsp_paddr,
  output logic                  rsp_uncached,
  output logic [2:0]            rsp_fault,
  output logic [CNT_W-1:0]      cnt_hit,
  output logic [CNT_W-1:0]      cnt_miss,
  output logic [CNT_W-1:0]      cnt_acv
);
  logic [63:0]         c_pa;
  logic                c_unc;
  ifx_fault_e          c_fault;
  logic [EV_N-1:0]     c_ev;
  logic [EV_N*CNT_W-1:0] cnt_flat;

  assign tlb_vpn = req_vaddr[VA_W-1:PG_SH];
  assign tlb_asn = req_asn;

  ifx_path #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH)) u_path (
    .vaddr(req_vaddr), .phys(req_phys), .mode(req_mode),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xperm(tlb_xperm),
    .paddr(c_pa), .uncached(c_unc), .fault(c_fault), .ev(c_ev)
  );

  ifx_counters #(.N(EV_N), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(c_ev & {EV_N{req_valid}}), .cnt(cnt_flat)
  );

  assign cnt_hit  = cnt_flat[EV_HIT*CNT_W  +: CNT_W];
  assign cnt_miss = cnt_flat[EV_MISS*CNT_W +: CNT_W];
  assign cnt_acv  = cnt_flat[EV_ACV*CNT_W  +: CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= FLT_NONE;
    end else begin
      rsp_valid    <= req_valid;
      rsp_paddr    <= c_pa;
      rsp_uncached <= c_unc;
      rsp_fault    <= c_fault;
    end
  end

  assert_valid_delay_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));
  assert_bypass_hit_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_vaddr[0] |=> rsp_fault == FLT_NONE && !rsp_uncached &&
      cnt_hit == $past(cnt_hit) + 1'b1);
  assert_pa_width_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONE |-> rsp_paddr[63:PA_W] == '0);
  assert_uc_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_uncached |-> rsp_paddr[PA_W-2:35] == '0 && rsp_paddr[PA_W-1]);
  assert_miss_step_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_miss == $past(cnt_miss) || cnt_miss == $past(cnt_miss) + 1'b1);
  assert_acv_step_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_acv == $past(cnt_acv) || cnt_acv == $past(cnt_acv) + 1'b1);
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(cnt_hit) && $stable(cnt_miss) && $stable(cnt_acv));
endmodule

// File: tb/tb_ifx_xlate.sv
`timescale 1ns/1ps
module tb_ifx_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic        req_phys = 1'b0;
  logic [1:0]  req_mode = '0;
  logic [7:0]  req_asn = '0;
  logic [34:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_xperm = '0;
  logic        rsp_valid, rsp_uncached;
  logic [63:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [15:0] cnt_hit, cnt_miss, cnt_acv;

  int checks = 0, errors = 0;
  int m_hit = 0, m_miss = 0, m_acv = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ifx_xlate dut (.*);

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input longint unsigned va, input bit ph, input int md, input bit th,
                       input longint unsigned pp, input int pm,
                       output longint unsigned epa, output bit eunc, output int ef,
                       output int dh, output int dm, output int da);
    longint unsigned top;
    bit late = 1;
    epa = 0; eunc = 0; ef = 0; dh = 0; dm = 0; da = 0;
    top = va >> 47;
    if (va % 2 == 1) begin
      epa = (va - (va % 4)) % (64'd1 << 44); dh = 1; late = 0;
    end else if (ph) begin
      epa = va;
    end else if (top != 0 && top != 64'h1FFFF) begin
      ef = 1; da = 1; late = 0;
    end else if (((va >> 41) % 128) == 126) begin
      if (md != 0) begin ef = 1; da = 1; late = 0; end
      else begin
        epa = va % (64'd1 << 44);
        if ((epa >> 40) % 2 == 1) epa = (epa % (64'd1 << 40)) + (64'hF << 40);
        else epa = epa % (64'd1 << 40);
      end
    end else if (!th) begin
      ef = 2; dm = 1; late = 0;
    end else begin
      epa = pp * 8192 + ((va % 8192) / 4) * 4;
      if (((pm >> md) % 2) == 0) begin ef = 1; da = 1; late = 0; end
      else dh = 1;
    end
    if (late) begin
      if ((epa >> 44) != 0) ef = 3;
      else if ((epa >> 43) % 2 == 1) begin
        if (((epa >> 32) % 2048) == 2047) ef = 4;
        else begin
          eunc = 1;
          epa = (epa % (64'd1 << 35)) + (64'd1 << 43);
        end
      end
    end
    if (ef != 0) begin epa = 0; eunc = 0; end
  endtask

  task automatic step(input bit v, input longint unsigned va, input bit ph, input int md,
                      input bit th, input longint unsigned pp, input int pm, input string req);
    longint unsigned epa; bit eunc; int ef, dh, dm, da;
    @(negedge clk);
    req_valid = v; req_vaddr = va; req_phys = ph; req_mode = md[1:0];
    req_asn = 8'h5A; tlb_hit = th; tlb_ppn = pp[30:0]; tlb_xperm = pm[3:0];
    model(va, ph, md, th, pp, pm, epa, eunc, ef, dh, dm, da);
    #1;
    // R7: lookup key follows the request in the same cycle
    chk(tlb_vpn == va[47:13] && tlb_asn == 8'h5A, "R7 lookup key", tlb_vpn, va[47:13]);
    @(posedge clk); #1;
    chk(rsp_valid == v, {req, " R12 valid"}, rsp_valid, v);
    if (v) begin
      m_hit += dh; m_miss += dm; m_acv += da;
      chk(rsp_fault == ef[2:0], {req, " fault"}, rsp_fault, ef);
      chk(rsp_paddr == epa, {req, " paddr"}, rsp_paddr, epa);
      chk(rsp_uncached == eunc, {req, " uncached"}, rsp_uncached, eunc);
    end
    chk(cnt_hit == m_hit[15:0], {req, " R12 hit count"}, cnt_hit, m_hit);
    chk(cnt_miss == m_miss[15:0], {req, " R12 miss count"}, cnt_miss, m_miss);
    chk(cnt_acv == m_acv[15:0], {req, " R12 acv count"}, cnt_acv, m_acv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0 && cnt_hit == 0 && cnt_miss == 0 && cnt_acv == 0, "R1 reset state", rsp_valid, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid == 0 && cnt_hit == 0, "R1 after reset", cnt_hit, 0);
    // R2 bypass, TLB miss ignored
    step(1, 64'h0000_1234_5678_9ABF, 1, 3, 0, 0, 0, "R2 bypass");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2, 0, 0, 0, "R2 bypass high");
    step(0, 64'h0, 0, 0, 0, 0, 0, "R12 idle");
    // R3 physical
    step(1, 64'h0000_0000_1000_2000, 1, 3, 0, 0, 0, "R3 phys plain");
    step(1, 64'h0004_0000_0000_0000, 1, 0, 1, 0, 15, "R10 phys mchk");
    step(1, 64'h0000_0812_3456_7FF8, 1, 0, 0, 0, 0, "R11 phys uncached");
    step(1, 64'h0000_0FFF_0000_0040, 1, 0, 0, 0, 0, "R11 phys unimp");
    // R4 non-canonical
    step(1, 64'h0001_0000_0000_0000, 0, 0, 1, 1, 15, "R4 noncanon");
    step(1, 64'hFFFF_0000_0000_1000, 0, 0, 1, 1, 15, "R4 noncanon neg");
    // R5/R6 superpage
    step(1, 64'hFFFF_FC00_1234_5670, 0, 0, 0, 0, 0, "R6 superpage low");
    step(1, 64'hFFFF_FD00_0000_1000, 0, 0, 0, 0, 0, "R6 superpage signext");
    step(1, 64'hFFFF_FDFF_F000_0000, 0, 0, 0, 0, 0, "R11 superpage unimp");
    step(1, 64'hFFFF_FC00_1234_5670, 0, 3, 1, 5, 15, "R5 superpage user");
    step(1, 64'hFFFF_FC00_0000_0000, 0, 1, 1, 5, 15, "R5 superpage exec mode");
    // R7 miss, R8/R9 hit
    step(1, 64'h0000_0000_0004_1ABE, 0, 2, 0, 7, 15, "R7 miss");
    step(1, 64'h0000_0000_0004_1ABE, 0, 2, 1, 31'h0123_4567, 4'b0100, "R8 hit");
    step(0, 64'h0000_0000_0004_1ABE, 0, 2, 0, 0, 0, "R12 idle2");
    step(1, 64'h0000_0000_0004_1ABE, 0, 2, 1, 31'h0123_4567, 4'b1011, "R9 denied");
    step(1, 64'hFFFF_8000_0000_2004, 0, 0, 1, 31'h4000_0001, 4'b0001, "R11 hit uncached");
    step(1, 64'h0000_0000_0000_0000, 0, 3, 1, 31'h7FF8_0000, 4'b1000, "R11 hit unimp");
    step(1, 64'h0000_0000_0000_2002, 0, 1, 1, 31'h0000_0010, 4'b0010, "R8 low bits");
    step(0, 64'h0, 0, 0, 0, 0, 0, "R12 final idle");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule